// File: doc/BRIEF.md
# Two-Wire Serial Data Buffer with Deferred Receive Hand-Off

This block sits between the bit-level engine of a two-wire serial bus and the processor. It has a single shift register that collects or sends one frame of 1 to 8 data bits, and a receive holding register with a full flag that the processor reads. A bit-level controller outside the block decides when each data bit is on the bus. It offers a bit to the block with a valid/ready strobe pair. It also reports each start condition with a one-cycle pulse. The block counts the bits of each frame against a programmed length. When a frame ends, the block passes the received word to the holding register. If the processor has not read the previous word yet, that pass waits until it does.

The bit interface carries the back-pressure. `bit_ready` is high while the block is enabled and no finished frame is waiting in the shift register. A bit counts only in a cycle where both `bit_valid` and `bit_ready` are high. If a frame finishes while the holding register is still full, `bit_ready` stays low until a processor read frees the holding register. Any strobe offered while `bit_ready` is low has no effect.

The block also checks the first frame after a start condition against a programmed 7-bit device address. The result is shown on `addr_hit`. The processor uses two registers: a data register, usable only while the block is enabled, and an address register, usable only while it is disabled.

Top module: `twi_data_buffer`

## Requirements
- R1: After reset, `rx_full`, `addr_hit` and `addr_phase` are 0. The holding register, the shift register and the address register are all zero.
- R2: `bit_ready` is 1 only while `enable` is 1 and no finished frame is waiting in the shift register. A bit strobe offered while `bit_ready` is 0 changes nothing.
- R3: In receive mode (`tx_mode`=0), when a frame ends and `rx_full` is 0, the received word is loaded into the holding register at that clock edge, and `rx_full` becomes 1.
- R4: In receive mode, a frame that ends while `rx_full` is 1 stays in the shift register, and `bit_ready` drops to 0. The next data read returns the older word and moves the waiting word in, with `rx_full` staying 1. A data read with no frame waiting clears `rx_full`.
- R5: When a frame ends in the same cycle as a data read that empties the holding register, the read returns the old word. At that edge the new word is loaded and `rx_full` stays 1.
- R6: In transmit mode (`tx_mode`=1), a finished frame never changes the holding register or `rx_full`.
- R7: In transmit mode, a data write loads the shift register. `bit_out` presents bit 7 first, shifting toward the MSB, when `lsb_first`=0, and bit 0 first, shifting toward the LSB, when `lsb_first`=1. A frame shorter than 8 bits therefore sends the top bits of the written word when `lsb_first`=0 and the bottom bits when `lsb_first`=1.
- R8: In receive mode, the first bit of a frame enters a cleared shift register. With `lsb_first`=0 a short frame ends LSB-justified, first bit highest. With `lsb_first`=1 it ends MSB-justified, first bit lowest. All unused bits read as 0.
- R9: `frame_len` values 1 to 7 give frames of that many bits, and the value 0 gives an 8-bit frame.
- R10: The data register (`reg_sel`=0) can be used only while `enable`=1. While `enable`=0, a data read returns 0 and a data write has no effect.
- R11: The address register (`reg_sel`=1) holds the device address in bits 7:1 and the format bit in bit 0. It can be written and read only while `enable`=0. While `enable`=1, writes to it are ignored and reads of it return 0.
- R12: When the first frame after a start condition ends, and the format bit is 0, `addr_hit` becomes 1 exactly when bits 7:1 of the received word equal the stored address. When the format bit is 1, `addr_hit` stays 0.
- R13: A start pulse, taken while enabled, clears `addr_hit`, sets `addr_phase` until the next frame ends, and restarts the frame bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| lsb_first | input | 1 | Bit order: 0 = MSB first, 1 = LSB first |
| frame_len | input | 3 | Data bits per frame, 0 meaning 8 |
| start_det | input | 1 | One-cycle start-condition pulse |
| bit_valid | input | 1 | Bus side offers a bit |
| bit_ready | output | 1 | Block accepts a bit this cycle |
| bit_in | input | 1 | Received serial bit |
| bit_out | output | 1 | Serial bit to transmit |
| reg_sel | input | 1 | 0 = data register, 1 = address register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data reads consume the held word) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_sel` and `enable` |
| rx_full | output | 1 | Holding register contains an unread word |
| addr_phase | output | 1 | Next frame is the address frame |
| addr_hit | output | 1 | Last address frame matched |

## Verification
The critical overlap is a frame ending in the same cycle that the processor reads the data register. That read would otherwise empty the holding register. The bench holds the last bit of a second frame in place, raises the read strobe on that same negative edge, and then releases both together. It checks that the read returns the first word, that `rx_full` stays set with `bit_ready` still high, and that the next read returns the second word. A second scenario lets the frame finish one cycle before the read, which must send the word down the deferred path with `bit_ready` low.

// File: rtl/twi_dbuf_pkg.sv
package twi_dbuf_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_ADDR = 1'b1
  } twi_reg_sel_e;
endpackage

// File: rtl/twi_shift_stage.sv
module twi_shift_stage #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_mode,
  input  logic          lsb_first,
  input  logic [CW-1:0] frame_len,
  input  logic          start,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  input  logic          bit_valid,
  input  logic          bit_ready,
  input  logic          bit_in,
  output logic          bit_out,
  output logic [W-1:0]  shift_q,
  output logic [W-1:0]  shift_next,
  output logic          frame_done
);
  logic [W-1:0]  sh_r;
  logic [W-1:0]  base;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_m1;
  logic          accept;
  logic          last;

  assign len_m1     = (frame_len == '0) ? CW'(W - 1) : frame_len - CW'(1);
  assign accept     = bit_valid && bit_ready;
  assign last       = (cnt_q == len_m1);
  assign frame_done = accept && last;
  assign shift_q    = sh_r;
  assign bit_out    = lsb_first ? sh_r[0] : sh_r[W-1];

  // receive frames start from a cleared word so unused bits read zero
  always_comb begin
    base       = (!tx_mode && cnt_q == '0) ? '0 : sh_r;
    shift_next = lsb_first ? {bit_in, base[W-1:1]} : {base[W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_r  <= '0;
      cnt_q <= '0;
    end else begin
      if (load)        sh_r <= load_data;
      else if (accept) sh_r <= shift_next;
      if (start)       cnt_q <= '0;
      else if (accept) cnt_q <= last ? '0 : cnt_q + CW'(1);
    end
  end

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready && !load) |=> $stable(sh_r));
  a_r13_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0));
endmodule

// File: rtl/twi_rx_hold.sv
module twi_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_mode,
  input  logic         frame_done,
  input  logic         rd_take,
  input  logic [W-1:0] shift_q,
  input  logic [W-1:0] shift_next,
  output logic [W-1:0] hold_q,
  output logic         full,
  output logic         pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      full    <= 1'b0;
      pending <= 1'b0;
    end else if (rd_take && pending) begin
      hold_q  <= shift_q;
      pending <= 1'b0;
    end else if (frame_done && !tx_mode) begin
      if (!full || rd_take) begin
        hold_q <= shift_next;
        full   <= 1'b1;
      end else begin
        pending <= 1'b1;
      end
    end else if (rd_take) begin
      full <= 1'b0;
    end
  end

  a_r4_pending_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> full);
  a_r4_no_frame_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !frame_done);
  a_r6_tx_never_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && tx_mode && !full) |=> !full);
  a_r5_collision_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !tx_mode && rd_take && full && !pending) |=> (full && !pending));
endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match #(
  parameter int W  = 8,
  parameter int AW = W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          frame_done,
  input  logic          fmt_sel,
  input  logic [AW-1:0] dev_addr,
  input  logic [W-1:0]  frame_word,
  output logic          addr_phase,
  output logic          addr_hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_phase <= 1'b0;
      addr_hit   <= 1'b0;
    end else if (start) begin
      addr_phase <= 1'b1;
      addr_hit   <= 1'b0;
    end else if (frame_done && addr_phase) begin
      addr_phase <= 1'b0;
      addr_hit   <= !fmt_sel && (frame_word[W-1 -: AW] == dev_addr);
    end
  end

  a_r13_start_clears_hit: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr_phase && !addr_hit));
  a_r12_hit_after_addr_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hit) |-> ($past(frame_done) && $past(addr_phase)));
endmodule

// File: rtl/twi_data_buffer.sv
module twi_data_buffer #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tx_mode,
  input  logic              lsb_first,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              start_det,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_in,
  output logic              bit_out,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rx_full,
  output logic              addr_phase,
  output logic              addr_hit
);
  import twi_dbuf_pkg::*;

  localparam int AW = DATA_W - 1;

  twi_reg_sel_e      sel;
  logic              data_acc;
  logic              addr_acc;
  logic              load;
  logic              rd_take;
  logic              start_g;
  logic              pending;
  logic              frame_done;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] shift_next;
  logic [DATA_W-1:0] hold_q;
  logic [AW-1:0]     dev_addr_q;
  logic              fmt_q;

  assign sel       = twi_reg_sel_e'(reg_sel);
  assign data_acc  = enable && (sel == SEL_DATA);
  assign addr_acc  = !enable && (sel == SEL_ADDR);
  assign load      = reg_wr && data_acc;
  assign rd_take   = reg_rd && data_acc;
  assign start_g   = start_det && enable;
  assign bit_ready = enable && !pending;

  always_comb begin
    if (data_acc)      reg_rdata = hold_q;
    else if (addr_acc) reg_rdata = {dev_addr_q, fmt_q};
    else               reg_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_addr_q <= '0;
      fmt_q      <= 1'b0;
    end else if (reg_wr && addr_acc) begin
      {dev_addr_q, fmt_q} <= reg_wdata;
    end
  end

  twi_shift_stage #(.W(DATA_W), .CW(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .lsb_first(lsb_first),
    .frame_len(frame_len), .start(start_g), .load(load), .load_data(reg_wdata),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_in(bit_in), .bit_out(bit_out),
    .shift_q(shift_q), .shift_next(shift_next), .frame_done(frame_done)
  );

  twi_rx_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .frame_done(frame_done),
    .rd_take(rd_take), .shift_q(shift_q), .shift_next(shift_next),
    .hold_q(hold_q), .full(rx_full), .pending(pending)
  );

  twi_addr_match #(.W(DATA_W), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start_g), .frame_done(frame_done),
    .fmt_sel(fmt_q), .dev_addr(dev_addr_q), .frame_word(shift_next),
    .addr_phase(addr_phase), .addr_hit(addr_hit)
  );

  a_r10_disabled_data_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && sel == SEL_DATA) |-> (reg_rdata == '0));
  a_r11_addr_locked_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({dev_addr_q, fmt_q}));
endmodule

// File: tb/twi_data_buffer_tb.sv
`timescale 1ns/1ps
module twi_data_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, tx_mode = 1'b0, lsb_first = 1'b0;
  logic [2:0] frame_len = 3'd0;
  logic       start_det = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       bit_ready, bit_out, rx_full, addr_phase, addr_hit;
  logic [7:0] reg_rdata;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  twi_data_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_mode(tx_mode), .lsb_first(lsb_first),
    .frame_len(frame_len), .start_det(start_det), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_in(bit_in), .bit_out(bit_out), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_full(rx_full),
    .addr_phase(addr_phase), .addr_hit(addr_hit)
  );

  // {tx, lsb_first, len, data/serial (first bit = bit 7), expected}
  localparam int NV = 11;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 8'hB2, 8'hB2},
    {1'b0, 1'b0, 3'd3, 8'hA0, 8'h05},
    {1'b0, 1'b1, 3'd3, 8'hC0, 8'h60},
    {1'b0, 1'b1, 3'd0, 8'h80, 8'h01},
    {1'b0, 1'b0, 3'd5, 8'hC8, 8'h19},
    {1'b0, 1'b1, 3'd1, 8'h80, 8'h80},
    {1'b0, 1'b0, 3'd1, 8'h80, 8'h01},
    {1'b1, 1'b0, 3'd3, 8'hA0, 8'hA0},
    {1'b1, 1'b1, 3'd3, 8'h05, 8'hA0},
    {1'b1, 1'b1, 3'd0, 8'h01, 8'h80},
    {1'b1, 1'b0, 3'd0, 8'h3C, 8'h3C}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic o);
    @(negedge clk);
    bit_in = b; bit_valid = 1'b1;
    #1 o = bit_out;
    @(posedge clk);
    #1 bit_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] ser, input logic [2:0] len, output logic [7:0] got);
    int nb;
    logic o;
    nb  = (len == 3'd0) ? 8 : int'(len);
    got = 8'h00;
    for (int i = 0; i < nb; i++) begin
      send_bit(ser[7-i], o);
      got[7-i] = o;
    end
  endtask

  task automatic write_reg(input logic s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_det = 1'b1;
    @(posedge clk);
    #1 start_det = 1'b0;
  endtask

  task automatic set_ctrl(input logic en, input logic tx, input logic lsb, input logic [2:0] len);
    @(negedge clk);
    enable = en; tx_mode = tx; lsb_first = lsb; frame_len = len;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, got;
    logic o;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 rx_full", {7'd0, rx_full}, 8'h00);
    chk("R1 addr_hit", {7'd0, addr_hit}, 8'h00);
    chk("R1 addr_phase", {7'd0, addr_phase}, 8'h00);
    chk("R2 ready low when disabled", {7'd0, bit_ready}, 8'h00);
    read_reg(1'b1, d);
    chk("R1 address register", d, 8'h00);

    // vector table: R3 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      e = VEC[v];
      set_ctrl(1'b1, e[20], e[19], e[18:16]);
      if (e[20]) begin
        write_reg(1'b0, e[15:8]);
        send_frame(8'h00, e[18:16], got);
        chk("R7 R9 tx bit stream", got, e[7:0]);
        #1 chk("R6 tx leaves rx_full", {7'd0, rx_full}, 8'h00);
      end else begin
        send_frame(e[15:8], e[18:16], got);
        #1 chk("R3 rx_full after frame", {7'd0, rx_full}, 8'h01);
        read_reg(1'b0, d);
        chk("R8 R9 rx justification", d, e[7:0]);
        #1 chk("R4 read clears full", {7'd0, rx_full}, 8'h00);
      end
    end

    // R10 write while disabled ignored (shift register is zero after last tx frame)
    set_ctrl(1'b0, 1'b1, 1'b0, 3'd0);
    write_reg(1'b0, 8'hFF);
    set_ctrl(1'b1, 1'b1, 1'b0, 3'd0);
    #1 chk("R10 disabled write ignored", {7'd0, bit_out}, 8'h00);

    // R10 read while disabled returns zero
    set_ctrl(1'b1, 1'b0, 1'b0, 3'd0);
    send_frame(8'h5A, 3'd0, got);
    set_ctrl(1'b0, 1'b0, 1'b0, 3'd0);
    read_reg(1'b0, d);
    chk("R10 disabled read zero", d, 8'h00);
    #1 chk("R10 disabled read keeps full", {7'd0, rx_full}, 8'h01);
    set_ctrl(1'b1, 1'b0, 1'b0, 3'd0);
    read_reg(1'b0, d);
    chk("R10 enabled read", d, 8'h5A);

    // R4 deferred transfer and R2 stall
    send_frame(8'h11, 3'd0, got);
    send_frame(8'h22, 3'd0, got);
    #1 chk("R4 full while pending", {7'd0, rx_full}, 8'h01);
    chk("R2 ready low while pending", {7'd0, bit_ready}, 8'h00);
    send_bit(1'b1, o);
    read_reg(1'b0, d);
    chk("R4 first read older word", d, 8'h11);
    #1 chk("R4 full stays after deferred move", {7'd0, rx_full}, 8'h01);
    chk("R2 ready back", {7'd0, bit_ready}, 8'h01);
    read_reg(1'b0, d);
    chk("R4 R2 second read newer word", d, 8'h22);
    #1 chk("R4 empty after second read", {7'd0, rx_full}, 8'h00);

    // R5 frame end coincides with emptying read
    send_frame(8'h33, 3'd0, got);
    send_frame(8'h44, 3'd7, got);
    @(negedge clk);
    bit_in = 1'b0; bit_valid = 1'b1; reg_sel = 1'b0; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 begin bit_valid = 1'b0; reg_rd = 1'b0; end
    chk("R5 collision read old", d, 8'h33);
    chk("R5 full kept", {7'd0, rx_full}, 8'h01);
    chk("R5 no stall", {7'd0, bit_ready}, 8'h01);
    read_reg(1'b0, d);
    chk("R5 new word loaded", d, 8'h44);

    // R11 address register access
    set_ctrl(1'b0, 1'b0, 1'b0, 3'd0);
    write_reg(1'b1, 8'hA0);
    read_reg(1'b1, d);
    chk("R11 address readback", d, 8'hA0);
    set_ctrl(1'b1, 1'b0, 1'b0, 3'd0);
    write_reg(1'b1, 8'h12);
    read_reg(1'b1, d);
    chk("R11 read zero when enabled", d, 8'h00);
    set_ctrl(1'b0, 1'b0, 1'b0, 3'd0);
    read_reg(1'b1, d);
    chk("R11 write ignored when enabled", d, 8'hA0);

    // R12 R13 address match
    set_ctrl(1'b1, 1'b0, 1'b0, 3'd0);
    pulse_start();
    chk("R13 addr_phase after start", {7'd0, addr_phase}, 8'h01);
    send_frame(8'hA1, 3'd0, got);
    #1 chk("R12 match", {7'd0, addr_hit}, 8'h01);
    chk("R13 phase ends with frame", {7'd0, addr_phase}, 8'h00);
    read_reg(1'b0, d);
    pulse_start();
    chk("R13 start clears hit", {7'd0, addr_hit}, 8'h00);
    send_frame(8'hA2, 3'd0, got);
    #1 chk("R12 mismatch", {7'd0, addr_hit}, 8'h00);
    read_reg(1'b0, d);
    pulse_start();
    send_bit(1'b1, o);
    send_bit(1'b1, o);
    pulse_start();
    send_frame(8'hA1, 3'd0, got);
    #1 chk("R13 bit count restarted, match", {7'd0, addr_hit}, 8'h01);
    read_reg(1'b0, d);
    chk("R13 clean word after restart", d, 8'hA1);
    set_ctrl(1'b0, 1'b0, 1'b0, 3'd0);
    write_reg(1'b1, 8'hA1);
    set_ctrl(1'b1, 1'b0, 1'b0, 3'd0);
    pulse_start();
    send_frame(8'hA1, 3'd0, got);
    #1 chk("R12 format bit 1 blocks match", {7'd0, addr_hit}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule